// File: doc/BRIEF.md
# Sequential Multiplier with Low and High Product Words

This block is a multi-cycle 32 by 32 bit multiplier for a small integer pipeline. A one-cycle start strobe presents a primary opcode, an extended opcode, two 32-bit sources and a 16-bit immediate. About three dozen cycles later the block returns one 32-bit word with a single-cycle done pulse. That word is either the low half of the 64-bit product or the high half of it. The high half is available for unsigned-by-unsigned, signed-by-unsigned and signed-by-signed operands.

A single 32-step loop produces both halves at once. One accumulator shifts left and collects partial products selected by the multiplier bits, most significant bit first. This gives the low word. A second accumulator adds partial products selected least significant bit first and shifts right, keeping the carry. This gives the unsigned high word. In one final correction cycle, the signed high words are formed from the unsigned high word. When the A source is negative, B is subtracted. When the B source is negative as well, A is subtracted too.

Top module: `seq_mul_hi`

## Requirements
- R1: With primary opcode 0x24 (immediate form) the imm input is sign-extended to 32 bits and used as operand B, and the result is the low 32 bits of src_a times that value; the extended opcode is not looked at.
- R2: With primary opcode 0x3a and extended opcode 0x27 the result is the low 32 bits of src_a times src_b.
- R3: With primary opcode 0x3a and extended opcode 0x07 the result is bits 63..32 of the unsigned product of src_a and src_b.
- R4: With primary opcode 0x3a and extended opcode 0x17 the result is bits 63..32 of the product of src_a read as signed and src_b read as unsigned.
- R5: With primary opcode 0x3a and extended opcode 0x1f the result is bits 63..32 of the product of both sources read as signed.
- R6: Any other combination of opcodes returns a result of 0 and still completes with a done pulse at the normal latency.
- R7: done is high for exactly one cycle, on the 35th rising clock edge counted from the edge that samples start, which is one load cycle, 32 loop cycles and one correction cycle later. result changes only in that same edge and then holds until the next completion.
- R8: busy is high from the edge that accepts start until the edge that raises done. A start while busy is high is ignored, and the result of the running operation is unaffected by it.
- R9: After reset, busy, done and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_prim | input | 6 | Primary opcode |
| op_ext | input | 6 | Extended opcode for register forms |
| src_a | input | 32 | Operand A (multiplicand) |
| src_b | input | 32 | Operand B (multiplier, register forms) |
| imm | input | 16 | Immediate, sign-extended for the immediate form |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Selected product word |

## Verification
Every result, including the zero returned for an unknown opcode, is due on the 35th rising edge counted from the edge that samples start. The bench drives start on a falling edge, then counts falling edges until done appears. It requires done to be seen on exactly the 35th of them and compares result there, against a 64-bit product computed in the bench. The falling edge after that must show done low again. Several more falling edges later, result must still hold its value. For the ignored second start, the bench raises start again in the middle of an operation and then checks that both the completion cycle and the value match the first operation.

// File: rtl/seq_mul_hi.sv
module seq_mul_hi #(
  parameter int W    = 32,
  parameter int IMMW = 16,
  parameter int OPW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OPW-1:0]  op_prim,
  input  logic [OPW-1:0]  op_ext,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [IMMW-1:0] imm,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    result
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [OPW-1:0] OP_IMM = OPW'(6'h24);
  localparam logic [OPW-1:0] OP_REG = OPW'(6'h3a);
  localparam logic [OPW-1:0] X_LO   = OPW'(6'h27);
  localparam logic [OPW-1:0] X_UU   = OPW'(6'h07);
  localparam logic [OPW-1:0] X_SU   = OPW'(6'h17);
  localparam logic [OPW-1:0] X_SS   = OPW'(6'h1f);
  localparam logic [2:0] M_LO = 3'd0, M_UU = 3'd1, M_SU = 3'd2, M_SS = 3'd3, M_BAD = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIX} st_t;

  st_t          st;
  logic [2:0]   mode_d, mode_q;
  logic [W-1:0] a_q, b_q, b_in;
  logic [W-1:0] mlo, mhi, lo, hi;
  logic [CW-1:0] cnt;
  logic [W:0]   hsum;
  logic [W-1:0] lo_next, fix_su, fix_ss;
  logic [W-1:0] res_d;

  always_comb begin
    mode_d = M_BAD;
    if (op_prim == OP_IMM) mode_d = M_LO;
    else if (op_prim == OP_REG) begin
      case (op_ext)
        X_LO:    mode_d = M_LO;
        X_UU:    mode_d = M_UU;
        X_SU:    mode_d = M_SU;
        X_SS:    mode_d = M_SS;
        default: mode_d = M_BAD;
      endcase
    end
  end

  assign b_in    = (op_prim == OP_IMM) ? {{(W-IMMW){imm[IMMW-1]}}, imm} : src_b;
  assign hsum    = {1'b0, hi} + (mhi[0] ? {1'b0, a_q} : '0);
  assign lo_next = {lo[W-2:0], 1'b0} + (mlo[W-1] ? a_q : '0);
  assign fix_su  = hi - (a_q[W-1] ? b_q : '0);
  assign fix_ss  = fix_su - (b_q[W-1] ? a_q : '0);
  assign busy    = (st != S_IDLE);

  always_comb begin
    case (mode_q)
      M_LO:    res_d = lo;
      M_UU:    res_d = hi;
      M_SU:    res_d = fix_su;
      M_SS:    res_d = fix_ss;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= M_BAD;
      a_q    <= '0;
      b_q    <= '0;
      mlo    <= '0;
      mhi    <= '0;
      lo     <= '0;
      hi     <= '0;
      cnt    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          a_q    <= src_a;
          b_q    <= b_in;
          mode_q <= mode_d;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          lo  <= '0;
          hi  <= '0;
          mlo <= b_q;
          mhi <= b_q;
          cnt <= '0;
          st  <= S_RUN;
        end
        S_RUN: begin
          lo  <= lo_next;
          hi  <= hsum[W:1];
          mlo <= {mlo[W-2:0], 1'b0};
          mhi <= {1'b0, mhi[W-1:1]};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W-1)) st <= S_FIX;
        end
        S_FIX: begin
          result <= res_d;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  operand_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(mode_q)));

  // R6
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_BAD) |-> result == '0);

  // R7
  loop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> cnt < CW'(W));
endmodule

// File: tb/tb_seq_mul_hi.sv
module tb_seq_mul_hi;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  op_prim = '0;
  logic [5:0]  op_ext = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  seq_mul_hi dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prim(op_prim), .op_ext(op_ext),
    .src_a(src_a), .src_b(src_b), .imm(imm), .busy(busy), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_val(input logic [5:0] p, input logic [5:0] x,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] im);
    logic [63:0] prod;
    if (p == 6'h24) begin
      prod = {{32{a[31]}}, a} * {{48{im[15]}}, im};
      return prod[31:0];
    end
    if (p != 6'h3a) return 32'h0;
    case (x)
      6'h27: begin prod = {32'h0, a} * {32'h0, b}; return prod[31:0]; end
      6'h07: begin prod = {32'h0, a} * {32'h0, b}; return prod[63:32]; end
      6'h17: begin prod = {{32{a[31]}}, a} * {32'h0, b}; return prod[63:32]; end
      6'h1f: begin prod = {{32{a[31]}}, a} * {{32{b[31]}}, b}; return prod[63:32]; end
      default: return 32'h0;
    endcase
  endfunction

  task automatic launch(input logic [5:0] p, input logic [5:0] x,
                        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
    @(negedge clk);
    op_prim = p; op_ext = x; src_a = a; src_b = b; imm = im; start = 1'b1;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (done) begin lat = i; break; end
    end
  endtask

  task automatic run_and_check(input string tag, input logic [5:0] p, input logic [5:0] x,
                               input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
    int lat;
    launch(p, x, a, b, im);
    wait_done(lat);
    chk({tag, " latency"}, 64'(lat), 64'd35);
    chk({tag, " value"}, {32'h0, result}, {32'h0, ref_val(p, x, a, b, im)});
  endtask

  task automatic t_reset;
    chk("R9 busy", {63'h0, busy}, 64'h0);
    chk("R9 done", {63'h0, done}, 64'h0);
    chk("R9 result", {32'h0, result}, 64'h0);
  endtask

  task automatic t_mul_low;
    run_and_check("R2 small", 6'h3a, 6'h27, 32'd7, 32'd6, 16'h0);
    run_and_check("R2 min by ones", 6'h3a, 6'h27, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
    run_and_check("R2 mixed", 6'h3a, 6'h27, 32'h1234_5678, 32'h9ABC_DEF1, 16'h0);
  endtask

  task automatic t_muli;
    run_and_check("R1 neg imm", 6'h24, 6'h00, 32'd1000, 32'hDEAD_BEEF, 16'hFFFD);
    run_and_check("R1 max imm", 6'h24, 6'h3f, 32'hFFFF_FFFF, 32'h0, 16'h7FFF);
    run_and_check("R1 min imm", 6'h24, 6'h07, 32'h8000_0001, 32'h5555_5555, 16'h8000);
  endtask

  task automatic t_high_uu;
    run_and_check("R3 ones", 6'h3a, 6'h07, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
    run_and_check("R3 mixed", 6'h3a, 6'h07, 32'h8000_0000, 32'hC000_0003, 16'h0);
  endtask

  task automatic t_high_su;
    run_and_check("R4 neg a", 6'h3a, 6'h17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
    run_and_check("R4 min a", 6'h3a, 6'h17, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);
    run_and_check("R4 pos a", 6'h3a, 6'h17, 32'h7654_3210, 32'h8000_0000, 16'h0);
  endtask

  task automatic t_high_ss;
    run_and_check("R5 min min", 6'h3a, 6'h1f, 32'h8000_0000, 32'h8000_0000, 16'h0);
    run_and_check("R5 ones", 6'h3a, 6'h1f, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
    run_and_check("R5 min ones", 6'h3a, 6'h1f, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
    run_and_check("R5 mixed", 6'h3a, 6'h1f, 32'h0001_0000, 32'hFFFE_1234, 16'h0);
  endtask

  task automatic t_bad;
    run_and_check("R6 bad ext", 6'h3a, 6'h25, 32'h1234_5678, 32'h2, 16'h0);
    run_and_check("R6 bad prim", 6'h00, 6'h27, 32'h3, 32'h5, 16'h1);
  endtask

  task automatic t_hold_and_pulse;
    int lat;
    logic [31:0] exp;
    exp = ref_val(6'h3a, 6'h07, 32'hDEAD_BEEF, 32'hCAFE_F00D, 16'h0);
    launch(6'h3a, 6'h07, 32'hDEAD_BEEF, 32'hCAFE_F00D, 16'h0);
    wait_done(lat);
    chk("R7 latency", 64'(lat), 64'd35);
    @(negedge clk);
    chk("R7 done single pulse", {63'h0, done}, 64'h0);
    chk("R8 busy low after done", {63'h0, busy}, 64'h0);
    src_a = 32'h1111_1111; src_b = 32'h2222_2222;
    repeat (5) @(negedge clk);
    chk("R7 result held", {32'h0, result}, {32'h0, exp});
  endtask

  task automatic t_start_while_busy;
    int lat;
    logic [31:0] exp;
    exp = ref_val(6'h3a, 6'h27, 32'h0000_0101, 32'h0000_0033, 16'h0);
    launch(6'h3a, 6'h27, 32'h0000_0101, 32'h0000_0033, 16'h0);
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", {63'h0, busy}, 64'h1);
    repeat (9) @(negedge clk);
    op_prim = 6'h3a; op_ext = 6'h1f; src_a = 32'h8000_0000; src_b = 32'h8000_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 11;
    for (int i = 12; i <= 60; i++) begin
      @(negedge clk);
      if (done) begin lat = i; break; end
    end
    chk("R8 ignored start latency", 64'(lat), 64'd35);
    chk("R8 ignored start value", {32'h0, result}, {32'h0, exp});
    @(negedge clk);
    chk("R8 no second run", {63'h0, busy}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mul_low();
    t_muli();
    t_high_uu();
    t_high_su();
    t_high_ss();
    t_bad();
    t_hold_and_pulse();
    t_start_while_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule